// File: doc/BRIEF.md
# Input Sample Capture with Gating or Zero-Stuffing

This block sits at the very front of a digital downconverter. Every clock it registers a 14-bit sample word and a per-cycle enable. It puts every sample into two's-complement form and passes the result on as a data word plus a valid flag. A format input states how the incoming word is coded. Offset-binary words are converted by flipping their most significant bit. Two's-complement words pass through unchanged.

A mode input picks one of two ways to qualify the stream. In gated mode the output is valid only on cycles that follow an enabled input cycle, and it carries exactly one sample per enabled cycle. This lets a slow sample source be clocked by a fast front-end clock. In zero-stuff mode the output is valid on every cycle. Enabled cycles carry the converted sample and all other cycles carry zero. A slow input stream is in this way interpolated up to the full clock rate before it reaches the filters. The format and mode inputs are registered together with the sample they go with, so a change applies from the very next sample. Both modes have the same single-register latency.

The asynchronous active-low reset clears the outputs at once. The release of reset is synchronized inside the block.

Top module: `ing_sample_ctrl`

## Requirements
- R1: With the format input low (two's complement), an enabled sample appears unchanged on the data output one rising edge after it is presented.
- R2: With the format input high (offset binary), an enabled sample appears on the data output one edge later with bit 13 inverted and bits 12..0 unchanged (0x2000 gives 0x0000, 0x0000 gives 0x2000).
- R3: With the mode input low (gated), the valid output after an edge equals the enable input sampled at that edge.
- R4: In gated mode, when the enable was low at an edge, the data output after that edge is zero.
- R5: With the mode input high (zero-stuff), the valid output after that edge is one, whether or not the enable was high.
- R6: In zero-stuff mode, the data output after an edge is the converted sample if the enable was high, and zero otherwise.
- R7: While reset is low, both outputs are zero. They are cleared as soon as reset falls, without waiting for a clock edge.
- R8: After reset rises, the first two rising edges capture nothing and the outputs stay zero. The third edge captures the inputs present at that edge.
- R9: Format and mode are taken per sample, so changing either between consecutive samples affects only the samples that follow the change, with the same one-edge latency in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Front-end sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| cfg_offset_bin | input | 1 | 1: input is offset binary, 0: two's complement |
| cfg_zero_stuff | input | 1 | 1: zero-stuff mode, 0: gated mode |
| smp_in | input | 14 | Input sample word |
| smp_en | input | 1 | Input sample enable |
| smp_out | output | 14 | Two's-complement output sample |
| smp_vld | output | 1 | Output sample valid |

## Verification
Every data and valid result is due after exactly one rising edge, in both modes. The bench sets the inputs on a falling edge and reads the outputs at the next falling edge, so exactly one register lies between stimulus and check. The reset results follow different timing. Clearing is checked one time unit after reset falls, with no edge in between. The release is checked at the falling edges after the second and the third rising edge that follow it.

// File: rtl/ing_pkg.sv
package ing_pkg;
  localparam int unsigned SAMPLE_W_DEF = 14;

  typedef enum logic {
    FMT_TWOS   = 1'b0,
    FMT_OFFSET = 1'b1
  } fmt_e;

  typedef enum logic {
    MODE_GATED = 1'b0,
    MODE_STUFF = 1'b1
  } mode_e;
endpackage

// File: rtl/ing_rst_sync.sv
module ing_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_nxt = 1'b1;
    end else begin : g_many
      always_comb sync_nxt = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/ing_fmt_conv.sv
module ing_fmt_conv
  import ing_pkg::*;
#(
  parameter int unsigned W = SAMPLE_W_DEF
) (
  input  logic [W-1:0] raw,
  input  fmt_e         fmt,
  output logic [W-1:0] conv
);
  localparam int unsigned MSB = W - 1;

  always_comb begin
    conv      = raw;
    conv[MSB] = raw[MSB] ^ (fmt == FMT_OFFSET);
  end
endmodule

// File: rtl/ing_stuff_sel.sv
module ing_stuff_sel
  import ing_pkg::*;
#(
  parameter int unsigned W = SAMPLE_W_DEF
) (
  input  logic [W-1:0] conv,
  input  logic         en,
  input  mode_e        mode,
  input  logic         vld_q,
  output logic [W-1:0] data_nxt,
  output logic         vld_nxt,
  output logic         data_ld
);
  always_comb begin
    data_nxt = en ? conv : '0;
    vld_nxt  = (mode == MODE_STUFF) ? 1'b1 : en;
    // Data is only ever non-zero while valid is high, so an idle gated
    // stream needs no register update.
    data_ld  = en | vld_q | (mode == MODE_STUFF);
  end
endmodule

// File: rtl/ing_sample_ctrl.sv
module ing_sample_ctrl
  import ing_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = SAMPLE_W_DEF,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_offset_bin,
  input  logic                cfg_zero_stuff,
  input  logic [SAMPLE_W-1:0] smp_in,
  input  logic                smp_en,
  output logic [SAMPLE_W-1:0] smp_out,
  output logic                smp_vld
);
  logic                rst_s_n;
  fmt_e                fmt;
  mode_e               mode;
  logic [SAMPLE_W-1:0] conv;
  logic [SAMPLE_W-1:0] data_nxt;
  logic                vld_nxt;
  logic                data_ld;
  logic [SAMPLE_W-1:0] data_q;
  logic                vld_q;

  assign fmt  = fmt_e'(cfg_offset_bin);
  assign mode = mode_e'(cfg_zero_stuff);

  ing_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  ing_fmt_conv #(.W(SAMPLE_W)) u_fmt_conv (
    .raw  (smp_in),
    .fmt  (fmt),
    .conv (conv)
  );

  ing_stuff_sel #(.W(SAMPLE_W)) u_stuff_sel (
    .conv     (conv),
    .en       (smp_en),
    .mode     (mode),
    .vld_q    (vld_q),
    .data_nxt (data_nxt),
    .vld_nxt  (vld_nxt),
    .data_ld  (data_ld)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_nxt;
      if (data_ld) data_q <= data_nxt;
    end
  end

  assign smp_out = data_q;
  assign smp_vld = vld_q;
endmodule

// File: rtl/ing_sample_ctrl_chk.sv
module ing_sample_ctrl_chk #(
  parameter int unsigned SAMPLE_W = 14
) (
  input logic                clk,
  input logic                rst_s_n,
  input logic                cfg_offset_bin,
  input logic                cfg_zero_stuff,
  input logic [SAMPLE_W-1:0] smp_in,
  input logic                smp_en,
  input logic [SAMPLE_W-1:0] smp_out,
  input logic                smp_vld
);
  localparam int unsigned MSB = SAMPLE_W - 1;

  // R1
  twos_pass_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (smp_en && !cfg_offset_bin) |=> (smp_out == $past(smp_in)));

  // R2
  offset_flip_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (smp_en && cfg_offset_bin) |=>
      (smp_out[MSB] != $past(smp_in[MSB])) &&
      (smp_out[MSB-1:0] == $past(smp_in[MSB-1:0])));

  // R3
  gated_vld_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cfg_zero_stuff |=> (smp_vld == $past(smp_en)));

  // R4 and R6: an idle input cycle yields a zero word in either mode
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !smp_en |=> (smp_out == '0));

  // R5
  stuff_vld_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    cfg_zero_stuff |=> smp_vld);

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    !rst_s_n |-> (!smp_vld && (smp_out == '0)));
endmodule

bind ing_sample_ctrl ing_sample_ctrl_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk            (clk),
  .rst_s_n        (rst_s_n),
  .cfg_offset_bin (cfg_offset_bin),
  .cfg_zero_stuff (cfg_zero_stuff),
  .smp_in         (smp_in),
  .smp_en         (smp_en),
  .smp_out        (smp_out),
  .smp_vld        (smp_vld)
);

// File: tb/test_ing_sample_ctrl.sv
module test_ing_sample_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 14;
  localparam int NVEC       = 12;

  // {in[13:0], en, offset_bin, zero_stuff, exp_vld, exp_data[13:0]}
  localparam logic [31:0] VECS [NVEC] = '{
    {14'h1234, 1'b1, 1'b0, 1'b0, 1'b1, 14'h1234},  // R1
    {14'h3FFF, 1'b1, 1'b0, 1'b0, 1'b1, 14'h3FFF},  // R1
    {14'h1555, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0000},  // R3 R4
    {14'h2000, 1'b1, 1'b1, 1'b0, 1'b1, 14'h0000},  // R2
    {14'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 14'h2000},  // R2
    {14'h3FFF, 1'b1, 1'b1, 1'b0, 1'b1, 14'h1FFF},  // R2
    {14'h0ABC, 1'b1, 1'b0, 1'b1, 1'b1, 14'h0ABC},  // R5 R6 R9
    {14'h0ABC, 1'b0, 1'b0, 1'b1, 1'b1, 14'h0000},  // R5 R6
    {14'h2000, 1'b0, 1'b1, 1'b1, 1'b1, 14'h0000},  // R6
    {14'h1000, 1'b1, 1'b1, 1'b1, 1'b1, 14'h3000},  // R2 R6
    {14'h2001, 1'b1, 1'b0, 1'b0, 1'b1, 14'h2001},  // R9
    {14'h3333, 1'b0, 1'b1, 1'b0, 1'b0, 14'h0000}   // R3 R4 R9
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_offset_bin;
  logic         cfg_zero_stuff;
  logic [W-1:0] smp_in;
  logic         smp_en;
  logic [W-1:0] smp_out;
  logic         smp_vld;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ing_sample_ctrl i_ing_sample_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_offset_bin (cfg_offset_bin),
    .cfg_zero_stuff (cfg_zero_stuff),
    .smp_in         (smp_in),
    .smp_en         (smp_en),
    .smp_out        (smp_out),
    .smp_vld        (smp_vld)
  );

  task automatic check(input string req, input logic exp_v, input logic [W-1:0] exp_d);
    checks++;
    if (smp_vld !== exp_v || smp_out !== exp_d) begin
      fails++;
      $display("FAIL %s: vld=%b data=%h, expected vld=%b data=%h",
               req, smp_vld, smp_out, exp_v, exp_d);
    end
  endtask

  task automatic drive(input logic [W-1:0] d, input logic e, input logic ofs, input logic stf);
    smp_in         = d;
    smp_en         = e;
    cfg_offset_bin = ofs;
    cfg_zero_stuff = stf;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(14'h3FFF, 1'b1, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    check("R7 reset state", 1'b0, '0);

    // R8: release, stay clear for two edges, capture on the third
    rst_n = 1'b1;
    drive(14'h0123, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    check("R8 held after two edges", 1'b0, '0);
    @(negedge clk);
    check("R8 first capture", 1'b1, 14'h0123);

    // Vector table walk: R1..R6, R9
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i][31:18], VECS[i][17], VECS[i][16], VECS[i][15]);
      @(negedge clk);
      check($sformatf("R1-6/R9 vector %0d", i), VECS[i][14], VECS[i][13:0]);
    end

    // R5 R6: zero-stuff with one enable in four
    for (int k = 0; k < 8; k++) begin
      drive(14'(16'h0100 + k), (k % 4) == 0, 1'b0, 1'b1);
      @(negedge clk);
      check("R5 R6 sparse stuff", 1'b1, ((k % 4) == 0) ? 14'(16'h0100 + k) : 14'h0);
    end

    // R3 R4: gated with one enable in three
    for (int k = 0; k < 6; k++) begin
      drive(14'(16'h0200 + k), (k % 3) == 0, 1'b0, 1'b0);
      @(negedge clk);
      check("R3 R4 sparse gated", (k % 3) == 0, ((k % 3) == 0) ? 14'(16'h0200 + k) : 14'h0);
    end

    // R7: asynchronous clear mid-stream, before any edge
    drive(14'h2AAA, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    check("R7 pre-reset value", 1'b1, 14'h2AAA);
    rst_n = 1'b0;
    #1;
    check("R7 async clear", 1'b0, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 capture after second release", 1'b1, 14'h2AAA);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule